// File: doc/BRIEF.md
# Process-Tagged Translation Cache

This block keeps a small set of recent page-to-frame translations so that an address can be translated without visiting the page table in memory. Every entry holds a virtual page number, the owning process identifier, a frame number and three attribute flags: modified, accessed and write-permitted. A lookup presents a virtual address, and all entries are compared at once against the page number of that address together with the current-process input. The frame number, the attribute flags and the entry index come back in the same cycle. The physical address is the frame number joined to the page offset, which passes through unchanged.

When no valid entry matches, the block raises a miss output. Logic outside the block then walks the page table and loads the translation through the refill port. A write that matches an entry without write permission raises a protection fault and does not report a hit. On a context switch, the surrounding logic can choose one of two commands. A full flush empties every entry and restarts replacement at entry 0. A clear-valid command drops every entry's validity but leaves the replacement pointer where it was. A single translation can also be removed by page number and process identifier.

Each refill picks its slot in a fixed order. If the same page and process are already present, the refill writes over that entry. Otherwise it takes the lowest-numbered empty entry. When every entry is in use, a rotating pointer chooses the entry to replace.

Top module: `ptag_tlb`

## Requirements
- R1: After reset every entry is invalid and the rotating pointer is at entry 0, so any lookup misses.
- R2: A lookup (`lk_valid`=1) hits in the same cycle when a valid entry holds both the page number `lk_vaddr[VA_W-1:OFS_W]` and a process id equal to `cur_pid`. On a hit, `lk_paddr` = {frame, `lk_vaddr[OFS_W-1:0]`}, `lk_way` is the entry index, and the flags of that entry appear on `lk_dirty`, `lk_refd` and `lk_writable`.
- R3: An entry whose page number matches but whose process id differs from `cur_pid` does not match, so the lookup misses.
- R4: With `lk_valid`=1 and no matching entry, `lk_miss`=1, `lk_hit`=0, `lk_prot_fault`=0, and `lk_paddr`, `lk_way` and the flag outputs are all zero. With `lk_valid`=0, `lk_hit`, `lk_miss` and `lk_prot_fault` are all zero and the data outputs are zero.
- R5: A write lookup (`lk_write`=1) that matches an entry whose write flag is 0 gives `lk_prot_fault`=1 and `lk_hit`=0, with the data outputs still showing that entry. A read of the same entry hits, and a write to a writable entry hits.
- R6: A refill (`ins_en`) whose key is not yet present fills the lowest-indexed invalid entry. The new entry can be looked up from the next cycle on.
- R7: When no entry is invalid, a refill replaces the entry selected by the rotating pointer. The pointer then moves on by one and wraps from the last entry to entry 0. A refill that uses an invalid entry, or that writes over an existing entry, leaves the pointer where it is.
- R8: A refill whose page number and process id match a valid entry writes over that same entry, so a key never matches more than one entry.
- R9: A single invalidate (`inv_en`) clears only the valid entry that matches both `mnt_vpn` and `mnt_pid`. An invalidate whose process id differs from the entry's id has no effect.
- R10: A flush (`flush_en`) invalidates every entry and returns the rotating pointer to entry 0.
- R11: A clear-valid command (`clrv_en`) invalidates every entry and keeps the rotating pointer at its current position.
- R12: When several maintenance strobes are raised in the same cycle, only one is carried out, in this order of precedence: flush, then clear-valid, then refill, then single invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pid | input | PID_W | Identifier of the running process |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a store |
| lk_vaddr | input | VPN_W+OFS_W | Virtual address to translate |
| lk_hit | output | 1 | Translation found and access permitted |
| lk_miss | output | 1 | No matching valid entry |
| lk_prot_fault | output | 1 | Store to an entry without write permission |
| lk_paddr | output | PFN_W+OFS_W | Physical address |
| lk_way | output | $clog2(ENTRIES) | Index of the matching entry |
| lk_dirty | output | 1 | Modified flag of the matching entry |
| lk_refd | output | 1 | Accessed flag of the matching entry |
| lk_writable | output | 1 | Write-permitted flag of the matching entry |
| mnt_vpn | input | VPN_W | Page number for refill or invalidate |
| mnt_pid | input | PID_W | Process id for refill or invalidate |
| ins_en | input | 1 | Refill strobe |
| ins_pfn | input | PFN_W | Frame number to load |
| ins_dirty | input | 1 | Modified flag to load |
| ins_refd | input | 1 | Accessed flag to load |
| ins_writable | input | 1 | Write-permitted flag to load |
| inv_en | input | 1 | Single-entry invalidate strobe |
| flush_en | input | 1 | Empty all entries and restart replacement |
| clrv_en | input | 1 | Clear all valid bits and keep the pointer |

## Verification
Lookups are tried in several forms: correct page with the correct process, correct page with another process, reads and writes against entries with and without write permission, and pages that were never loaded or that were removed. Together these show that the process tag and the valid bit both gate a match, and that a fault is kept apart from a hit. The refill order is checked by filling the array from empty, punching a hole with a single invalidate, and then running past capacity. The index reported for each refill shows apart lowest-free selection, in-place overwrite and rotating replacement. The two context-switch commands are each followed by a full refill and one further refill, and the slot that refill takes shows whether the pointer was reset or kept. Strobes raised together confirm which maintenance command takes precedence.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

  typedef enum logic [2:0] {
    MNT_IDLE,
    MNT_FLUSH,
    MNT_CLRV,
    MNT_INSERT,
    MNT_INVAL
  } mnt_op_e;

  // Precedence: flush, clear-valid, refill, single invalidate.
  function automatic mnt_op_e mnt_decode(input logic flush, input logic clrv,
                                         input logic ins, input logic inv);
    mnt_op_e op;
    if (flush)     op = MNT_FLUSH;
    else if (clrv) op = MNT_CLRV;
    else if (ins)  op = MNT_INSERT;
    else if (inv)  op = MNT_INVAL;
    else           op = MNT_IDLE;
    return op;
  endfunction

endpackage

// File: rtl/ptlb_cam.sv
module ptlb_cam #(
  parameter int N  = 8,
  parameter int KW = 15,
  parameter int DW = 22,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vld_i,
  input  logic [KW-1:0] key_i  [N],
  input  logic [DW-1:0] data_i [N],
  input  logic [KW-1:0] probe_i,
  output logic [N-1:0]  match_o,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [DW-1:0] data_o
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = vld_i[g] && (key_i[g] == probe_i);
  end

  assign any_o = |match_o;

  // OR-select: at most one row matches by construction of the refill path.
  always_comb begin
    data_o = '0;
    idx_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (match_o[i]) begin
        data_o = data_o | data_i[i];
        idx_o  = idx_o | IW'(i);
      end
    end
  end

endmodule

// File: rtl/ptlb_prienc.sv
module ptlb_prienc #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/ptlb_rr.sv
module ptlb_rr #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [IW-1:0] ptr_o
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  assign ptr_en = clr_i | adv_i;

  always_comb begin
    if (clr_i)              ptr_d = '0;
    else if (ptr_q == LAST) ptr_d = '0;
    else                    ptr_d = ptr_q + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/ptag_tlb.sv
module ptag_tlb
  import ptlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 11,
  parameter int OFS_W   = 13,
  parameter int PFN_W   = 19,
  parameter int PID_W   = 4,
  localparam int VA_W = VPN_W + OFS_W,
  localparam int PA_W = PFN_W + OFS_W,
  localparam int IW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PID_W-1:0] cur_pid,
  input  logic             lk_valid,
  input  logic             lk_write,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_prot_fault,
  output logic [PA_W-1:0]  lk_paddr,
  output logic [IW-1:0]    lk_way,
  output logic             lk_dirty,
  output logic             lk_refd,
  output logic             lk_writable,
  input  logic [VPN_W-1:0] mnt_vpn,
  input  logic [PID_W-1:0] mnt_pid,
  input  logic             ins_en,
  input  logic [PFN_W-1:0] ins_pfn,
  input  logic             ins_dirty,
  input  logic             ins_refd,
  input  logic             ins_writable,
  input  logic             inv_en,
  input  logic             flush_en,
  input  logic             clrv_en
);

  localparam int KW = PID_W + VPN_W;
  localparam int DW = PFN_W + 3;

  // ---------------- entry state ----------------
  logic [ENTRIES-1:0] v_q, v_d;
  logic [KW-1:0]      key_q [ENTRIES];
  logic [KW-1:0]      key_d [ENTRIES];
  logic [DW-1:0]      dat_q [ENTRIES];
  logic [DW-1:0]      dat_d [ENTRIES];
  logic               st_en;

  mnt_op_e op;
  assign op    = mnt_decode(flush_en, clrv_en, ins_en, inv_en);
  assign st_en = (op != MNT_IDLE);

  // ---------------- lookup path ----------------
  logic [ENTRIES-1:0] lk_match;
  logic               lk_any;
  logic [IW-1:0]      lk_idx;
  logic [DW-1:0]      lk_data;
  logic [KW-1:0]      lk_probe;

  assign lk_probe = {cur_pid, lk_vaddr[VA_W-1:OFS_W]};

  ptlb_cam #(.N(ENTRIES), .KW(KW), .DW(DW)) u_look (
    .vld_i   (v_q),
    .key_i   (key_q),
    .data_i  (dat_q),
    .probe_i (lk_probe),
    .match_o (lk_match),
    .any_o   (lk_any),
    .idx_o   (lk_idx),
    .data_o  (lk_data)
  );

  // ---------------- maintenance key path ----------------
  logic [ENTRIES-1:0] mk_match;
  logic               mk_any;
  logic [IW-1:0]      mk_idx;
  logic [DW-1:0]      mk_data;
  logic [KW-1:0]      mk_probe;

  assign mk_probe = {mnt_pid, mnt_vpn};

  ptlb_cam #(.N(ENTRIES), .KW(KW), .DW(DW)) u_mkey (
    .vld_i   (v_q),
    .key_i   (key_q),
    .data_i  (dat_q),
    .probe_i (mk_probe),
    .match_o (mk_match),
    .any_o   (mk_any),
    .idx_o   (mk_idx),
    .data_o  (mk_data)
  );

  // ---------------- victim selection ----------------
  logic          free_found;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] rr_ptr;
  logic          rr_adv;
  logic [IW-1:0] vict;

  ptlb_prienc #(.N(ENTRIES)) u_free (
    .req_i   (~v_q),
    .found_o (free_found),
    .idx_o   (free_idx)
  );

  assign rr_adv = (op == MNT_INSERT) && !mk_any && !free_found;

  ptlb_rr #(.N(ENTRIES)) u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (op == MNT_FLUSH),
    .adv_i (rr_adv),
    .ptr_o (rr_ptr)
  );

  always_comb begin
    if (mk_any)          vict = mk_idx;
    else if (free_found) vict = free_idx;
    else                 vict = rr_ptr;
  end

  // ---------------- next state ----------------
  always_comb begin
    v_d = v_q;
    for (int i = 0; i < ENTRIES; i++) begin
      key_d[i] = key_q[i];
      dat_d[i] = dat_q[i];
    end
    unique case (op)
      MNT_FLUSH: begin
        v_d = '0;
        for (int i = 0; i < ENTRIES; i++) begin
          key_d[i] = '0;
          dat_d[i] = '0;
        end
      end
      MNT_CLRV: v_d = '0;
      MNT_INSERT: begin
        v_d[vict]   = 1'b1;
        key_d[vict] = mk_probe;
        dat_d[vict] = {ins_pfn, ins_dirty, ins_refd, ins_writable};
      end
      MNT_INVAL: begin
        if (mk_any) v_d[mk_idx] = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        key_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else if (st_en) begin
      v_q <= v_d;
      for (int i = 0; i < ENTRIES; i++) begin
        key_q[i] <= key_d[i];
        dat_q[i] <= dat_d[i];
      end
    end
  end

  // ---------------- lookup outputs ----------------
  logic lk_sel;
  logic ent_w;

  assign lk_sel = lk_valid && lk_any;
  assign ent_w  = lk_data[0];

  assign lk_hit        = lk_sel && !(lk_write && !ent_w);
  assign lk_prot_fault = lk_sel && lk_write && !ent_w;
  assign lk_miss       = lk_valid && !lk_any;
  assign lk_paddr      = lk_sel ? {lk_data[DW-1:3], lk_vaddr[OFS_W-1:0]} : '0;
  assign lk_way        = lk_sel ? lk_idx : '0;
  assign lk_dirty      = lk_sel && lk_data[2];
  assign lk_refd       = lk_sel && lk_data[1];
  assign lk_writable   = lk_sel && lk_data[0];

  // ---------------- assertions ----------------
  // R8: the refill path never creates a second row for the same key.
  p_single_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R5: a request resolves to exactly one of hit, miss, fault.
  p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $countones({lk_hit, lk_miss, lk_prot_fault}) == 1);

  // R4: nothing is reported without a request.
  p_quiet_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_prot_fault));

  // R6: a refill is resident in the chosen row one cycle later.
  p_refill_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == MNT_INSERT) |=> v_q[$past(vict)] && (key_q[$past(vict)] == $past(mk_probe)));

  // R9: a matched single invalidate clears its row.
  p_inval_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == MNT_INVAL) && mk_any |=> !v_q[$past(mk_idx)]);

  // R10: flush empties the array and rewinds replacement.
  p_flush_rewinds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == MNT_FLUSH) |=> (v_q == '0) && (rr_ptr == '0));

  // R11: clear-valid empties the array but holds the pointer.
  p_clrv_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op == MNT_CLRV) |=> (v_q == '0) && $stable(rr_ptr));

endmodule

// File: tb/ptag_tlb_test.sv
module ptag_tlb_test;

  localparam int VPN_W = 11, OFS_W = 13, PFN_W = 19, PID_W = 4, ENTRIES = 8;
  localparam int VA_W = VPN_W + OFS_W, PA_W = PFN_W + OFS_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [PID_W-1:0] cur_pid = '0;
  logic             lk_valid = 1'b0, lk_write = 1'b0;
  logic [VA_W-1:0]  lk_vaddr = '0;
  logic             lk_hit, lk_miss, lk_prot_fault;
  logic [PA_W-1:0]  lk_paddr;
  logic [2:0]       lk_way;
  logic             lk_dirty, lk_refd, lk_writable;
  logic [VPN_W-1:0] mnt_vpn = '0;
  logic [PID_W-1:0] mnt_pid = '0;
  logic             ins_en = 1'b0;
  logic [PFN_W-1:0] ins_pfn = '0;
  logic             ins_dirty = 1'b0, ins_refd = 1'b0, ins_writable = 1'b0;
  logic             inv_en = 1'b0, flush_en = 1'b0, clrv_en = 1'b0;

  always #5 clk = ~clk;

  ptag_tlb uut (
    .clk(clk), .rst_n(rst_n), .cur_pid(cur_pid),
    .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_prot_fault(lk_prot_fault),
    .lk_paddr(lk_paddr), .lk_way(lk_way),
    .lk_dirty(lk_dirty), .lk_refd(lk_refd), .lk_writable(lk_writable),
    .mnt_vpn(mnt_vpn), .mnt_pid(mnt_pid),
    .ins_en(ins_en), .ins_pfn(ins_pfn), .ins_dirty(ins_dirty),
    .ins_refd(ins_refd), .ins_writable(ins_writable),
    .inv_en(inv_en), .flush_en(flush_en), .clrv_en(clrv_en)
  );

  typedef struct {
    logic [40:0] vec;   // {hit, miss, fault, way[2:0], perm[2:0], paddr[31:0]}
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  function automatic logic [40:0] observed();
    return {lk_hit, lk_miss, lk_prot_fault, lk_way,
            lk_dirty, lk_refd, lk_writable, lk_paddr};
  endfunction

  // Monitor: compares each live lookup against the scoreboard head.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (lk_valid) begin
        n_run++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL scoreboard: unexpected lookup act=%h exp=<none>", observed());
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (observed() !== e.vec) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", e.tag, observed(), e.vec);
          end
        end
      end
    end
  end

  // Driver: one lookup held for one cycle; expected result pushed.
  task automatic look(input logic [VPN_W-1:0] vpn, input logic wr,
                      input logic eh, input logic em, input logic ef,
                      input logic [PFN_W-1:0] pfn, input logic [2:0] way,
                      input logic [2:0] perm, input string tag);
    exp_t e;
    logic [OFS_W-1:0] off;
    off = OFS_W'(vpn * 37 + 5);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_write = wr;
    lk_vaddr = {vpn, off};
    e.vec = {eh, em, ef, way, perm, ((eh | ef) ? {pfn, off} : 32'h0)};
    if (em) e.vec[37:32] = 6'h0;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic hit(input logic [VPN_W-1:0] vpn, input logic [PFN_W-1:0] pfn,
                     input logic [2:0] way, input logic [2:0] perm, input string tag);
    look(vpn, 1'b0, 1'b1, 1'b0, 1'b0, pfn, way, perm, tag);
  endtask

  task automatic miss(input logic [VPN_W-1:0] vpn, input string tag);
    look(vpn, 1'b0, 1'b0, 1'b1, 1'b0, '0, 3'd0, 3'd0, tag);
  endtask

  task automatic end_look();
    @(negedge clk);
    lk_valid = 1'b0;
    lk_write = 1'b0;
  endtask

  task automatic ins(input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid,
                     input logic [PFN_W-1:0] pfn, input logic [2:0] dwr);
    @(negedge clk);
    lk_valid = 1'b0;
    lk_write = 1'b0;
    mnt_vpn = vpn; mnt_pid = pid; ins_pfn = pfn;
    {ins_dirty, ins_refd, ins_writable} = dwr;
    ins_en = 1'b1;
    @(negedge clk);
    ins_en = 1'b0;
  endtask

  task automatic strobe(input logic f, input logic c, input logic i, input logic v,
                        input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid);
    @(negedge clk);
    lk_valid = 1'b0;
    lk_write = 1'b0;
    mnt_vpn = vpn; mnt_pid = pid; ins_pfn = 19'h3ABC;
    {ins_dirty, ins_refd, ins_writable} = 3'b001;
    flush_en = f; clrv_en = c; ins_en = i; inv_en = v;
    @(negedge clk);
    flush_en = 1'b0; clrv_en = 1'b0; ins_en = 1'b0; inv_en = 1'b0;
  endtask

  // Watchdog
  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_pid = 4'd1;

    // R4: idle request reports nothing
    @(negedge clk);
    #2;
    n_run++;
    if (observed() !== 41'h0) begin
      n_fail++;
      $display("FAIL R4 idle: act=%h exp=%h", observed(), 41'h0);
    end

    miss(11'd5, "R1 empty after reset");

    ins(11'd5, 4'd1, 19'h00123, 3'b011);
    hit(11'd5, 19'h00123, 3'd0, 3'b011, "R2 basic hit way0");
    hit(11'd5, 19'h00123, 3'd0, 3'b011, "R2 repeat hit");

    ins(11'd9, 4'd2, 19'h00077, 3'b100);
    miss(11'd9, "R3 foreign pid misses");
    end_look();
    cur_pid = 4'd2;
    hit(11'd9, 19'h00077, 3'd1, 3'b100, "R5 read of read-only hits");
    look(11'd9, 1'b1, 1'b0, 1'b0, 1'b1, 19'h00077, 3'd1, 3'b100, "R5 write faults");
    end_look();
    cur_pid = 4'd1;
    look(11'd5, 1'b1, 1'b1, 1'b0, 1'b0, 19'h00123, 3'd0, 3'b011, "R5 write to writable hits");
    miss(11'd6, "R4 unknown page misses");

    ins(11'd5, 4'd1, 19'h00456, 3'b111);
    hit(11'd5, 19'h00456, 3'd0, 3'b111, "R8 overwrite in place");

    for (int k = 0; k < 6; k++) ins(11'(20 + k), 4'd1, 19'(32'h200 + k), 3'b001);
    hit(11'd20, 19'h00200, 3'd2, 3'b001, "R6 lowest free way2");
    hit(11'd25, 19'h00205, 3'd7, 3'b001, "R6 lowest free way7");

    strobe(1'b0, 1'b0, 1'b0, 1'b1, 11'd21, 4'd1);
    miss(11'd21, "R9 invalidated entry misses");
    hit(11'd22, 19'h00202, 3'd4, 3'b001, "R9 neighbour untouched");
    strobe(1'b0, 1'b0, 1'b0, 1'b1, 11'd22, 4'd2);
    hit(11'd22, 19'h00202, 3'd4, 3'b001, "R9 wrong-pid invalidate ignored");

    ins(11'd30, 4'd1, 19'h00300, 3'b001);
    hit(11'd30, 19'h00300, 3'd3, 3'b001, "R6 refill takes hole way3");

    ins(11'd40, 4'd1, 19'h00400, 3'b001);
    hit(11'd40, 19'h00400, 3'd0, 3'b001, "R7 full: pointer victim way0");
    miss(11'd5, "R7 evicted entry gone");
    ins(11'd41, 4'd1, 19'h00401, 3'b001);
    hit(11'd41, 19'h00401, 3'd1, 3'b001, "R7 pointer advanced way1");

    strobe(1'b0, 1'b1, 1'b0, 1'b0, 11'd0, 4'd0);
    miss(11'd40, "R11 clear-valid empties");
    miss(11'd30, "R11 clear-valid empties all");
    for (int k = 0; k < 8; k++) ins(11'(50 + k), 4'd1, 19'(32'h500 + k), 3'b001);
    hit(11'd57, 19'h00507, 3'd7, 3'b001, "R6 refill after clear way7");
    ins(11'd60, 4'd1, 19'h00600, 3'b001);
    hit(11'd60, 19'h00600, 3'd2, 3'b001, "R11 pointer kept at way2");
    miss(11'd52, "R11 way2 evicted");

    strobe(1'b1, 1'b0, 1'b0, 1'b0, 11'd0, 4'd0);
    miss(11'd60, "R10 flush empties");
    for (int k = 0; k < 8; k++) ins(11'(70 + k), 4'd1, 19'(32'h700 + k), 3'b001);
    ins(11'd80, 4'd1, 19'h00800, 3'b001);
    hit(11'd80, 19'h00800, 3'd0, 3'b001, "R10 pointer rewound to way0");
    miss(11'd70, "R10 way0 evicted");

    strobe(1'b1, 1'b0, 1'b1, 1'b1, 11'd90, 4'd1);
    miss(11'd90, "R12 flush beats refill");
    miss(11'd71, "R12 flush applied");
    ins(11'd92, 4'd1, 19'h00920, 3'b001);
    strobe(1'b0, 1'b1, 1'b1, 1'b0, 11'd91, 4'd1);
    miss(11'd91, "R12 clear-valid beats refill");
    miss(11'd92, "R12 clear-valid applied");
    strobe(1'b0, 1'b0, 1'b1, 1'b1, 11'd93, 4'd1);
    hit(11'd93, 19'h03ABC, 3'd0, 3'b001, "R12 refill beats invalidate");
    end_look();

    repeat (2) @(negedge clk);
    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: act=%0d pending exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule